// File: doc/BRIEF.md
# Four-Voice Wavetable Oscillator Mixer

This block produces a stereo sample stream from four table-lookup oscillators. Each voice keeps a 32-bit phase accumulator and a 32-bit step value. Both are fixed point with 15 fractional bits and 24 significant bits. When a sample strobe is accepted, every voice adds its step to its phase and stores the result. Bits 23:15 of the new phase then select one of 512 entries in an 8-bit table. Voices 0 and 1 look up table memory A, and voices 2 and 3 look up table memory B. The four unsigned samples are added, divided by four, and the same byte is sent to the left and right outputs.

A host sets the oscillators through a small word-wide register window and can read every register back at any time. The table lookups are spread over several clocks. Each clock issues one read to memory A and one to memory B, and each memory returns its data one clock later. A finished sample appears with a one-cycle valid pulse. Filling the tables, volume and conversion to analog are handled outside this block.

Top module: `wt_mixer4`

## Requirements
- R1: After reset, both outputs read 8'h80, out_valid is low, and every phase and step register reads 0.
- R2: The register window is byte addressed, and reg_addr[1:0] is not decoded. Voice v has its phase word at 0x10 + 8*v and its step word at 0x14 + 8*v. A read of any other address returns 0, and a write to any other address changes no register.
- R3: On an accepted strobe, each voice's phase becomes (phase + step) mod 2^32, and that value can be read back afterwards.
- R4: The table index of a voice is bits 23:15 of its newly advanced phase. Bits 31:24 and 14:0 have no effect on which entry is read.
- R5: Voices 0 and 1 read memory A at address {1'b0, index}. Voices 2 and 3 read memory B at address {1'b1, index}, which is 512 + index. The two memories are always read in the same cycles, and each returns data one clock after the address.
- R6: The output is the 10-bit sum of the four unsigned samples shifted right by 2, driven identically on out_l and out_r. Four samples of 8'hFF give 8'hFF.
- R7: out_valid is high for exactly one cycle. The new output is registered on the third rising edge after the edge that accepted the strobe. Between pulses the outputs hold their value.
- R8: A strobe is accepted only when op_mode[1:0] equals 2'b10, whatever the upper mode bits are. Any other mode causes no phase advance, no table read and no output pulse.
- R9: A strobe that arrives while a sample is still being built is ignored.
- R10: A register written between strobes takes effect at the next strobe. If a phase write lands on the same edge as an accepted strobe, the written value is what stays in the register. The sample for that strobe still uses the advanced phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 8 | Mode byte; generation runs when bits 1:0 are 2'b10 |
| sample_stb | input | 1 | One-cycle request for the next output sample |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tbl_a_rd | output | 1 | Read enable, table memory A |
| tbl_a_addr | output | 10 | Address, table memory A |
| tbl_a_data | input | 8 | Data from memory A, one clock after the address |
| tbl_b_rd | output | 1 | Read enable, table memory B |
| tbl_b_addr | output | 10 | Address, table memory B |
| tbl_b_data | input | 8 | Data from memory B, one clock after the address |
| out_l | output | 8 | Left output sample |
| out_r | output | 8 | Right output sample |
| out_valid | output | 1 | One-cycle pulse when a new sample is presented |

## Verification
The table contents differ between A and B and are keyed to the index. A design that took the index from the wrong phase bits, or from the phase before the advance, would therefore miss the expected value. So would a design that dropped the memory-select bit. Phases are loaded with junk in bits 31:24 and 14:0, and all four voices are steered to a 8'hFF entry. A truncated sum or a leak of the upper bits shows up as a wrong byte. Other tests cover strobes held across the busy window, strobes sent in inactive modes (including 2'b11 and a mode with upper bits set), and a phase write landing on the same edge as a strobe. A design that advanced twice, ignored the mode, or let the advance overwrite the host write would show a wrong phase readback or an extra output pulse.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int NV       = 4;
    localparam int VSEL_W   = $clog2(NV);
    localparam int VPM      = NV / 2;
    localparam int PH_W     = 32;
    localparam int IDX_LSB  = 15;
    localparam int IDX_W    = 9;
    localparam int SMP_W    = 8;
    localparam int TBL_AW   = IDX_W + 1;
    localparam int ACC_W    = SMP_W + VSEL_W;
    localparam int STEP_W   = $clog2(VPM + 1);
    localparam int ADDR_W   = 6;
    localparam int REG_BASE = 16;
    localparam int REG_END  = REG_BASE + NV * 8;

    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic [NV-1:0][PH_W-1:0]  phase;
        logic [NV-1:0][PH_W-1:0]  step;
        logic [NV-1:0][IDX_W-1:0] idx;
    } rf_state_t;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] slot;
        logic [ACC_W-1:0]  acc;
        logic [SMP_W-1:0]  smp;
        logic              vld;
    } mix_state_t;
endpackage

// File: rtl/wt_regfile.sv
module wt_regfile
    import wt_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [PH_W-1:0]              wdata,
    output logic [PH_W-1:0]              rdata,
    output logic [NV-1:0][IDX_W-1:0]     idx_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(REG_END);

    rf_state_t rf_d, rf_q;
    logic [NV-1:0][PH_W-1:0] adv;
    logic [ADDR_W-1:0]       off;
    logic [VSEL_W-1:0]       sel_v;
    logic                    sel_step;
    logic                    hit;

    always_comb begin
        off      = addr - BASE_A;
        sel_v    = off[VSEL_W+2:3];
        sel_step = off[2];
        hit      = (addr >= BASE_A) && (addr < END_A);
        rf_d     = rf_q;
        for (int v = 0; v < NV; v++) begin
            adv[v] = rf_q.phase[v] + rf_q.step[v];
            if (advance) begin
                rf_d.phase[v] = adv[v];
                rf_d.idx[v]   = adv[v][IDX_LSB +: IDX_W];
            end
        end
        if (hit && we) begin
            if (sel_step) rf_d.step[sel_v]  = wdata;
            else          rf_d.phase[sel_v] = wdata;
        end
        rdata = '0;
        if (hit) rdata = sel_step ? rf_q.step[sel_v] : rf_q.phase[sel_v];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign idx_o = rf_q.idx;
endmodule

// File: rtl/wt_mix_seq.sv
module wt_mix_seq
    import wt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NV-1:0][IDX_W-1:0] idx_i,
    output logic                     busy,
    output logic                     a_rd,
    output logic [TBL_AW-1:0]        a_addr,
    input  logic [SMP_W-1:0]         a_data,
    output logic                     b_rd,
    output logic [TBL_AW-1:0]        b_addr,
    input  logic [SMP_W-1:0]         b_data,
    output logic [SMP_W-1:0]         smp_o,
    output logic                     vld_o
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(VPM);
    localparam logic [SMP_W-1:0]  MID  = SMP_W'(1) << (SMP_W - 1);

    mix_state_t m_d, m_q;
    logic [VSEL_W-1:0] va, vb;
    logic [ACC_W-1:0]  sum;

    always_comb begin
        m_d     = m_q;
        m_d.vld = 1'b0;
        a_rd    = 1'b0;
        b_rd    = 1'b0;
        a_addr  = '0;
        b_addr  = '0;
        va      = VSEL_W'(m_q.slot);
        vb      = VSEL_W'(VPM) + va;
        sum     = m_q.acc;
        if (!m_q.busy) begin
            if (start) begin
                m_d.busy = 1'b1;
                m_d.slot = '0;
                m_d.acc  = '0;
            end
        end else begin
            if (m_q.slot < LAST) begin
                a_rd   = 1'b1;
                b_rd   = 1'b1;
                a_addr = {1'b0, idx_i[va]};
                b_addr = {1'b1, idx_i[vb]};
            end
            if (m_q.slot != '0)
                sum = m_q.acc + ACC_W'(a_data) + ACC_W'(b_data);
            m_d.acc = sum;
            if (m_q.slot == LAST) begin
                m_d.smp  = sum[ACC_W-1 -: SMP_W];
                m_d.vld  = 1'b1;
                m_d.busy = 1'b0;
            end else begin
                m_d.slot = m_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q     <= '0;
            m_q.smp <= MID;
        end else begin
            m_q <= m_d;
        end
    end

    assign busy  = m_q.busy;
    assign smp_o = m_q.smp;
    assign vld_o = m_q.vld;
endmodule

// File: rtl/wt_mixer4.sv
module wt_mixer4
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_mode,
    input  logic              sample_stb,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PH_W-1:0]   reg_wdata,
    output logic [PH_W-1:0]   reg_rdata,
    output logic              tbl_a_rd,
    output logic [TBL_AW-1:0] tbl_a_addr,
    input  logic [SMP_W-1:0]  tbl_a_data,
    output logic              tbl_b_rd,
    output logic [TBL_AW-1:0] tbl_b_addr,
    input  logic [SMP_W-1:0]  tbl_b_data,
    output logic [SMP_W-1:0]  out_l,
    output logic [SMP_W-1:0]  out_r,
    output logic              out_valid
);
    logic                     busy;
    logic                     go;
    logic [NV-1:0][IDX_W-1:0] idx;
    logic [SMP_W-1:0]         smp;

    assign go = sample_stb && (op_mode[1:0] == 2'b10) && !busy;

    wt_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (go),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .idx_o   (idx)
    );

    wt_mix_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .idx_i  (idx),
        .busy   (busy),
        .a_rd   (tbl_a_rd),
        .a_addr (tbl_a_addr),
        .a_data (tbl_a_data),
        .b_rd   (tbl_b_rd),
        .b_addr (tbl_b_addr),
        .b_data (tbl_b_data),
        .smp_o  (smp),
        .vld_o  (out_valid)
    );

    assign out_l = smp;
    assign out_r = smp;
endmodule

// File: rtl/wt_mixer4_chk.sv
module wt_mixer4_chk
    import wt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tbl_a_rd,
    input logic [TBL_AW-1:0] tbl_a_addr,
    input logic              tbl_b_rd,
    input logic [TBL_AW-1:0] tbl_b_addr,
    input logic [SMP_W-1:0]  out_l,
    input logic [SMP_W-1:0]  out_r,
    input logic              out_valid
);
    // R5
    tbl_a_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_a_rd |-> !tbl_a_addr[TBL_AW-1]);
    // R5
    tbl_b_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_b_rd |-> tbl_b_addr[TBL_AW-1]);
    // R5
    rd_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_a_rd == tbl_b_rd);
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_l));
    // R6
    lr_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_l == out_r);
endmodule

bind wt_mixer4 wt_mixer4_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_a_rd   (tbl_a_rd),
    .tbl_a_addr (tbl_a_addr),
    .tbl_b_rd   (tbl_b_rd),
    .tbl_b_addr (tbl_b_addr),
    .out_l      (out_l),
    .out_r      (out_r),
    .out_valid  (out_valid)
);

// File: tb/wt_mixer4_tb.sv
module wt_mixer4_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_mode = 8'h02;
    logic        sample_stb = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tbl_a_rd, tbl_b_rd;
    logic [9:0]  tbl_a_addr, tbl_b_addr;
    logic [7:0]  tbl_a_data = '0, tbl_b_data = '0;
    logic [7:0]  out_l, out_r;
    logic        out_valid;

    always #4 clk = ~clk;

    wt_mixer4 u_dut (.*);

    int nchk = 0, nfail = 0, cyc = 0, vcnt = 0, rdcnt = 0, badsel = 0;
    bit done = 0;
    logic [31:0] m_ph [4];
    logic [31:0] m_inc [4];

    function automatic logic [7:0] mem_a(input logic [8:0] i);
        return (i == 9'd300) ? 8'hFF : 8'(i * 37 + 11);
    endfunction
    function automatic logic [7:0] mem_b(input logic [8:0] i);
        return (i == 9'd300) ? 8'hFF : 8'(i * 91 + 5);
    endfunction

    always @(posedge clk) begin
        if (tbl_a_rd) tbl_a_data <= mem_a(tbl_a_addr[8:0]);
        if (tbl_b_rd) tbl_b_data <= mem_b(tbl_b_addr[8:0]);
        if (tbl_a_rd) rdcnt++;
        if ((tbl_a_rd && tbl_a_addr[9]) || (tbl_b_rd && !tbl_b_addr[9])) badsel++;
        if (out_valid) vcnt++;
        cyc++;
        if (cyc > 100000 && !done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_out();
        logic [9:0] s = '0;
        for (int v = 0; v < 4; v++) begin
            logic [8:0] ix = m_ph[v][23:15];
            s += (v < 2) ? 10'(mem_a(ix)) : 10'(mem_b(ix));
        end
        return s[9:2];
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic phases_chk(input string req);
        for (int v = 0; v < 4; v++) rd_chk(req, 6'(16 + 8 * v), m_ph[v]);
    endtask

    task automatic wait_out(input string req, input logic [7:0] exp);
        repeat (2) @(negedge clk);
        check({req, " R7 no early pulse"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        check({req, " R7 pulse"}, 32'(out_valid), 32'd1);
        check({req, " R6 left"}, 32'(out_l), 32'(exp));
        check({req, " R6 right"}, 32'(out_r), 32'(exp));
        @(negedge clk);
        check({req, " R7 single"}, 32'(out_valid), 32'd0);
        check({req, " R7 hold"}, 32'(out_l), 32'(exp));
    endtask

    task automatic fire(input string req);
        logic [7:0] e;
        @(negedge clk); sample_stb = 1'b1;
        @(negedge clk); sample_stb = 1'b0;
        for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_inc[v];
        e = model_out();
        wait_out(req, e);
        phases_chk({req, " R3 phase"});
    endtask

    // {mode, step0, step1, step2, step3}
    localparam logic [135:0] VEC [6] = '{
        {8'h02, 32'h0000_8000, 32'h0001_0000, 32'h0001_8000, 32'h0002_0000},
        {8'h02, 32'h0012_3456, 32'h00AB_CDEF, 32'h0000_7FFF, 32'h00FF_8000},
        {8'h06, 32'hFFFF_8000, 32'h0100_0000, 32'h0080_0001, 32'h0033_3333},
        {8'h02, 32'h7F00_4000, 32'h0000_0001, 32'h00FF_FFFF, 32'h0055_AA55},
        {8'hFE, 32'h0001_0000, 32'h0002_8000, 32'h00C0_0000, 32'h0000_0000},
        {8'h02, 32'h0040_0000, 32'h0020_0000, 32'h0010_0000, 32'h0008_0000}
    };

    initial begin
        int vc, rc;
        logic [7:0] e;
        for (int v = 0; v < 4; v++) begin m_ph[v] = '0; m_inc[v] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_l", 32'(out_l), 32'h80);
        check("R1 out_r", 32'(out_r), 32'h80);
        check("R1 valid", 32'(out_valid), 32'd0);
        rd_chk("R1 phase2", 6'h20, 32'd0);
        rd_chk("R1 step3", 6'h2C, 32'd0);
        // R2 window decode
        wr(6'h30, 32'hDEAD_BEEF);
        wr(6'h0C, 32'h1234_5678);
        rd_chk("R2 read outside high", 6'h30, 32'd0);
        rd_chk("R2 read outside low", 6'h0C, 32'd0);
        wr(6'h24, 32'hCAFE_F00D);
        rd_chk("R2 step2 at 0x24", 6'h24, 32'hCAFE_F00D);
        rd_chk("R2 phase2 untouched", 6'h20, 32'd0);
        phases_chk("R2 stray writes");
        // vector table: R3 R4 R5 R6 R8
        for (int i = 0; i < 6; i++) begin
            for (int v = 0; v < 4; v++) begin
                m_inc[v] = VEC[i][127 - 32 * v -: 32];
                wr(6'(20 + 8 * v), m_inc[v]);
            end
            op_mode = VEC[i][135:128];
            fire("R3 R4 R5 vector");
        end
        op_mode = 8'h02;
        // R4 R6 ignored phase bits, full-scale sum
        for (int v = 0; v < 4; v++) begin
            m_inc[v] = '0;
            wr(6'(20 + 8 * v), 32'd0);
            m_ph[v] = 32'hAB00_0000 | (32'd300 << 15) | 32'h0000_7FFF;
            wr(6'(16 + 8 * v), m_ph[v]);
        end
        fire("R4 R6 full scale");
        // R10 written phase used at next strobe
        m_ph[3] = 32'h0123_4567; wr(6'h28, m_ph[3]);
        m_inc[3] = 32'h0001_8000; wr(6'h2C, m_inc[3]);
        fire("R10 write then strobe");
        // R8 inactive modes
        foreach (m_inc[v]) begin m_inc[v] = 32'h0003_0000; wr(6'(20 + 8 * v), m_inc[v]); end
        for (int k = 0; k < 3; k++) begin
            op_mode = (k == 0) ? 8'h01 : (k == 1) ? 8'h03 : 8'hF0;
            vc = vcnt; rc = rdcnt;
            @(negedge clk); sample_stb = 1'b1;
            @(negedge clk); sample_stb = 1'b0;
            repeat (5) @(negedge clk);
            check("R8 no pulse", 32'(vcnt), 32'(vc));
            check("R8 no table read", 32'(rdcnt), 32'(rc));
            phases_chk("R8 no advance");
        end
        op_mode = 8'h02;
        // R9 strobe held through the busy window
        vc = vcnt;
        @(negedge clk); sample_stb = 1'b1;
        repeat (4) @(negedge clk);
        sample_stb = 1'b0;
        for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_inc[v];
        e = model_out();
        repeat (3) @(negedge clk);
        check("R9 one pulse", 32'(vcnt), 32'(vc + 1));
        check("R9 sample", 32'(out_l), 32'(e));
        phases_chk("R9 single advance");
        // R10 write on the accepting edge
        @(negedge clk);
        sample_stb = 1'b1; reg_we = 1'b1; reg_addr = 6'h18; reg_wdata = 32'h5A5A_0000;
        @(negedge clk);
        sample_stb = 1'b0; reg_we = 1'b0;
        for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_inc[v];
        e = model_out();
        m_ph[1] = 32'h5A5A_0000;
        wait_out("R10 collision", e);
        phases_chk("R10 write wins");
        check("R5 memory select bit", 32'(badsel), 32'd0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule